// File: doc/BRIEF.md
# I2S Status Flag and Interrupt Unit

This block holds the status flags of a serial audio port whose transmit and receive paths each have a single-word buffer, and it drives the port's interrupt request. The serial shifter reports events to it as one-cycle strobes: a received word is complete, the transmit buffer has been moved into the shifter, a data item starts, and a data item ends. Software activity arrives as strobes too: a write to the transmit buffer, a read of the data register and a read of the status register.

From these events the unit keeps the transmit-empty, receive-full, busy, channel, overrun and underrun flags. It also gives a write enable for the receive data register, so that a word arriving during an overrun never replaces the word software has not yet read. Three enables mask the interrupt sources, and both error flags share one of them.

Top module: `i2s_flag_unit`

## Requirements
- R1: After reset the transmit-empty flag is 1. The receive-full, busy, channel, overrun and underrun flags are all 0.
- R2: A received word is accepted when the port is enabled, no overrun is pending, and the receive-full flag is 0 or a data read happens in the same cycle. An accepted word raises `rx_capture` in that cycle and sets the receive-full flag after the next edge. A data read with no word accepted clears the flag.
- R3: A received word that arrives while the receive-full flag is 1 and no data read is under way sets the overrun flag. That word is discarded: `rx_capture` stays 0 and the earlier word is kept.
- R4: While the overrun flag is 1, every received word is dropped. `rx_capture` stays 0 and the receive-full flag is not set again.
- R5: The overrun flag clears only on a status read that comes in a later cycle than a data read made while the flag was set. A status read with no such earlier data read leaves the flag set.
- R6: A write to the transmit buffer clears the transmit-empty flag. A load into the shifter sets it again. When both happen in the same cycle, the write wins.
- R7: In slave transmit mode, a data-item start while the transmit-empty flag is 1 sets the underrun flag. A status read clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: Outside PCM mode, the channel flag takes `chan_in` when the transmit-empty flag is set (in transmit mode) or when a received word is accepted (in receive mode). In PCM mode the channel flag keeps its value.
- R9: The busy flag is set by a data-item start and cleared by a data-item end. An end followed by a start in the next cycle therefore gives busy low for exactly one cycle.
- R10: While the port is disabled, the busy, overrun and underrun flags are held at 0.
- R11: `irq` is 1 whenever any of these holds: transmit-empty and `te_ie` are both 1; receive-full and `rne_ie` are both 1; `err_ie` is 1 and either the overrun or the underrun flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| slave_mode | input | 1 | 1 = port is a clock slave |
| pcm_mode | input | 1 | 1 = PCM framing |
| chan_in | input | CHAN_W | Channel of the current word (0 = left) |
| rx_word_done | input | 1 | Strobe: received word complete |
| tx_buf_wr | input | 1 | Strobe: transmit buffer written |
| tx_buf_load | input | 1 | Strobe: transmit buffer moved into the shifter |
| word_start | input | 1 | Strobe: first clock edge of a data item |
| word_end | input | 1 | Strobe: data item finished |
| dat_rd | input | 1 | Strobe: data register read |
| sts_rd | input | 1 | Strobe: status register read |
| te_ie | input | 1 | Transmit-empty interrupt enable |
| rne_ie | input | 1 | Receive-full interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| te_flag | output | 1 | Transmit buffer empty |
| rne_flag | output | 1 | Receive buffer holds an unread word |
| busy_flag | output | 1 | Data item in progress |
| chan_side | output | CHAN_W | Channel of the last word buffered |
| ovr_flag | output | 1 | Receive overrun |
| udr_flag | output | 1 | Transmit underrun |
| rx_capture | output | 1 | Write enable for the receive data register |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with the default one-bit channel field, which is the only width where the left/right capture of R8 means something. With that width, one table walks a complete receive sequence: an accepted word, an overrun, a status read that leaves the overrun set, dropped words, and the ordered clear. It then switches to transmit mode and covers the empty-flag handshake, underrun and the one-cycle busy gap. Directed cases then test the same-cycle priorities, PCM hold, clearing on disable, and each interrupt source with its enable.

// File: rtl/i2s_flag_pkg.sv
package i2s_flag_pkg;

  localparam logic TE_RESET = 1'b1;

  function automatic logic irq_any(
    input logic te, input logic rne, input logic ovr, input logic udr,
    input logic te_ie, input logic rne_ie, input logic err_ie);
    logic src_tx, src_rx, src_err;
    src_tx  = te & te_ie;
    src_rx  = rne & rne_ie;
    src_err = (ovr | udr) & err_ie;
    return src_tx | src_rx | src_err;
  endfunction

endpackage

// File: rtl/i2s_rx_track.sv
module i2s_rx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic rx_word_done,
  input  logic dat_rd,
  input  logic sts_rd,
  output logic rne,
  output logic ovr,
  output logic accept,
  output logic ovr_hit
);
  logic dat_seen;

  assign accept  = port_en & rx_word_done & ~ovr & (~rne | dat_rd);
  assign ovr_hit = port_en & rx_word_done & ~ovr & rne & ~dat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rne <= 1'b0;
    end else if (accept) begin
      rne <= 1'b1;
    end else if (dat_rd) begin
      rne <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr      <= 1'b0;
      dat_seen <= 1'b0;
    end else if (!port_en) begin
      ovr      <= 1'b0;
      dat_seen <= 1'b0;
    end else if (ovr_hit) begin
      ovr      <= 1'b1;
      dat_seen <= 1'b0;
    end else if (ovr && sts_rd && dat_seen) begin
      ovr      <= 1'b0;
      dat_seen <= 1'b0;
    end else if (ovr && dat_rd) begin
      dat_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/i2s_tx_track.sv
module i2s_tx_track
  import i2s_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic tx_mode,
  input  logic slave_mode,
  input  logic tx_buf_wr,
  input  logic tx_buf_load,
  input  logic word_start,
  input  logic sts_rd,
  output logic te,
  output logic udr,
  output logic te_set,
  output logic udr_hit
);
  assign te_set  = tx_buf_load & ~tx_buf_wr;
  assign udr_hit = port_en & slave_mode & tx_mode & word_start & te;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te <= TE_RESET;
    end else if (tx_buf_wr) begin
      te <= 1'b0;
    end else if (te_set) begin
      te <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      udr <= 1'b0;
    end else if (!port_en) begin
      udr <= 1'b0;
    end else if (udr_hit) begin
      udr <= 1'b1;
    end else if (sts_rd) begin
      udr <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_busy_track.sv
module i2s_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic word_start,
  input  logic word_end,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (!port_en) begin
      busy <= 1'b0;
    end else if (word_start) begin
      busy <= 1'b1;
    end else if (word_end) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_flag_unit.sv
module i2s_flag_unit
  import i2s_flag_pkg::*;
#(
  parameter int CHAN_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_mode,
  input  logic              slave_mode,
  input  logic              pcm_mode,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic              rx_word_done,
  input  logic              tx_buf_wr,
  input  logic              tx_buf_load,
  input  logic              word_start,
  input  logic              word_end,
  input  logic              dat_rd,
  input  logic              sts_rd,
  input  logic              te_ie,
  input  logic              rne_ie,
  input  logic              err_ie,
  output logic              te_flag,
  output logic              rne_flag,
  output logic              busy_flag,
  output logic [CHAN_W-1:0] chan_side,
  output logic              ovr_flag,
  output logic              udr_flag,
  output logic              rx_capture,
  output logic              irq
);
  logic rx_accept, ovr_hit, te_set, udr_hit, side_load;

  i2s_rx_track u_rx (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .rx_word_done(rx_word_done), .dat_rd(dat_rd), .sts_rd(sts_rd),
    .rne(rne_flag), .ovr(ovr_flag), .accept(rx_accept), .ovr_hit(ovr_hit)
  );

  i2s_tx_track u_tx (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_mode(tx_mode),
    .slave_mode(slave_mode), .tx_buf_wr(tx_buf_wr), .tx_buf_load(tx_buf_load),
    .word_start(word_start), .sts_rd(sts_rd),
    .te(te_flag), .udr(udr_flag), .te_set(te_set), .udr_hit(udr_hit)
  );

  i2s_busy_track u_busy (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .word_start(word_start), .word_end(word_end), .busy(busy_flag)
  );

  assign side_load  = ~pcm_mode & (tx_mode ? te_set : rx_accept);
  assign rx_capture = rx_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_side <= '0;
    end else if (side_load) begin
      chan_side <= chan_in;
    end
  end

  assign irq = irq_any(te_flag, rne_flag, ovr_flag, udr_flag, te_ie, rne_ie, err_ie);
endmodule

// File: rtl/i2s_flag_unit_chk.sv
module i2s_flag_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic tx_mode,
  input logic slave_mode,
  input logic rx_word_done,
  input logic tx_buf_wr,
  input logic word_start,
  input logic word_end,
  input logic dat_rd,
  input logic sts_rd,
  input logic te_ie,
  input logic te_flag,
  input logic rne_flag,
  input logic busy_flag,
  input logic ovr_flag,
  input logic udr_flag,
  input logic rx_capture,
  input logic irq
);
  a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_capture |=> rne_flag);
  a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && rx_word_done && rne_flag && !dat_rd && !ovr_flag |=> ovr_flag);
  a_r4_no_capture_in_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> !rx_capture);
  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && ovr_flag && !sts_rd |=> ovr_flag);
  a_r6_write_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_buf_wr |=> !te_flag);
  a_r7_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && slave_mode && tx_mode && word_start && te_flag |=> udr_flag);
  a_r9_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && word_end && !word_start |=> !busy_flag);
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !busy_flag && !ovr_flag && !udr_flag);
  a_r11_te_irq: assert property (@(posedge clk) disable iff (!rst_n)
    te_flag && te_ie |-> irq);
endmodule

bind i2s_flag_unit i2s_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_mode(tx_mode),
  .slave_mode(slave_mode), .rx_word_done(rx_word_done), .tx_buf_wr(tx_buf_wr),
  .word_start(word_start), .word_end(word_end), .dat_rd(dat_rd), .sts_rd(sts_rd),
  .te_ie(te_ie), .te_flag(te_flag), .rne_flag(rne_flag), .busy_flag(busy_flag),
  .ovr_flag(ovr_flag), .udr_flag(udr_flag), .rx_capture(rx_capture), .irq(irq)
);

// File: tb/i2s_flag_unit_bench.sv
module i2s_flag_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en, tx_mode, slave_mode, pcm_mode;
  logic [0:0] chan_in;
  logic rx_word_done, tx_buf_wr, tx_buf_load, word_start, word_end, dat_rd, sts_rd;
  logic te_ie, rne_ie, err_ie;
  logic te_flag, rne_flag, busy_flag, ovr_flag, udr_flag, rx_capture, irq;
  logic [0:0] chan_side;

  int n_checks = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_flag_unit u_i2s_flag_unit (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_mode(tx_mode),
    .slave_mode(slave_mode), .pcm_mode(pcm_mode), .chan_in(chan_in),
    .rx_word_done(rx_word_done), .tx_buf_wr(tx_buf_wr), .tx_buf_load(tx_buf_load),
    .word_start(word_start), .word_end(word_end), .dat_rd(dat_rd), .sts_rd(sts_rd),
    .te_ie(te_ie), .rne_ie(rne_ie), .err_ie(err_ie),
    .te_flag(te_flag), .rne_flag(rne_flag), .busy_flag(busy_flag),
    .chan_side(chan_side), .ovr_flag(ovr_flag), .udr_flag(udr_flag),
    .rx_capture(rx_capture), .irq(irq)
  );

  // inputs: en txm slv pcm ch rxd txw txl ws we dr sr | expected: cap te rne busy chs ovr udr
  localparam logic [18:0] VEC [NVEC] = '{
    19'b1010_0000_0000_0100000, // 0  R1 idle
    19'b1010_0000_1000_0101000, // 1  R9 start
    19'b1010_1100_0100_1110100, // 2  R2 R8 R9 accept left/right=1
    19'b1010_0000_1000_0111100, // 3  R9
    19'b1010_0100_0100_0110110, // 4  R3 overrun, word discarded
    19'b1010_0000_0001_0110110, // 5  R5 status read alone keeps overrun
    19'b1010_0100_0000_0110110, // 6  R4 dropped
    19'b1010_0000_0010_0100110, // 7  R2 R5 data read
    19'b1010_0100_0000_0100110, // 8  R4 dropped, rne stays 0
    19'b1010_0000_0001_0100100, // 9  R5 ordered clear
    19'b1010_0100_0000_1110000, // 10 R2 R8 accept, channel 0
    19'b1010_0000_0010_0100000, // 11 R2 read clears
    19'b1110_0010_0000_0000000, // 12 R6 write empties
    19'b1110_1001_0000_0100100, // 13 R6 R8 load, channel 1
    19'b1110_0000_1000_0101101, // 14 R7 R9 underrun and start
    19'b1110_0000_0001_0101100, // 15 R7 status read clears
    19'b1110_0000_0100_0100100, // 16 R9 end
    19'b1110_0000_1000_0101101, // 17 R9 R7 restart after one low cycle
    19'b0110_0000_0000_0100100  // 18 R10 disable
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {rx_word_done, tx_buf_wr, tx_buf_load, word_start, word_end, dat_rd, sts_rd} = '0;
    chan_in = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    port_en = 1'b0; tx_mode = 1'b0; slave_mode = 1'b1; pcm_mode = 1'b0;
    te_ie = 1'b0; rne_ie = 1'b0; err_ie = 1'b0;
    idle_inputs();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 te", {7'd0, te_flag}, 8'd1);
    chk("R1 rne/busy/chs/ovr/udr", {3'd0, rne_flag, busy_flag, chan_side, ovr_flag, udr_flag}, 8'd0);

    for (int i = 0; i < NVEC; i++) begin
      {port_en, tx_mode, slave_mode, pcm_mode, chan_in, rx_word_done, tx_buf_wr,
       tx_buf_load, word_start, word_end, dat_rd, sts_rd} = VEC[i][18:7];
      #1;
      chk($sformatf("R2/R3/R4 capture row %0d", i), {7'd0, rx_capture}, {7'd0, VEC[i][6]});
      @(posedge clk); #1;
      chk($sformatf("vector row %0d flags", i),
          {2'd0, te_flag, rne_flag, busy_flag, chan_side, ovr_flag, udr_flag},
          {2'd0, VEC[i][5:0]});
      idle_inputs();
    end

    // R6 write wins over load in the same cycle
    do_reset(); port_en = 1'b1; tx_mode = 1'b1;
    tx_buf_wr = 1'b1; tx_buf_load = 1'b1; tick();
    chk("R6 write wins", {7'd0, te_flag}, 8'd0);

    // R7 set wins over status read
    tx_buf_load = 1'b1; tick();
    word_start = 1'b1; sts_rd = 1'b1; tick();
    chk("R7 set wins over read", {7'd0, udr_flag}, 8'd1);
    // R11 error interrupt via underrun
    err_ie = 1'b1; #1;
    chk("R11 underrun irq", {7'd0, irq}, 8'd1);
    err_ie = 1'b0; #1;
    chk("R11 masked", {7'd0, irq}, 8'd0);
    te_ie = 1'b1; #1;
    chk("R11 te irq", {7'd0, irq}, 8'd1);
    te_ie = 1'b0;

    // R8 PCM mode holds channel
    do_reset(); port_en = 1'b1; pcm_mode = 1'b1;
    chan_in = 1'b1; rx_word_done = 1'b1; tick();
    chk("R8 pcm hold", {7'd0, chan_side}, 8'd0);
    chk("R2 pcm accept", {7'd0, rne_flag}, 8'd1);
    rne_ie = 1'b1; #1;
    chk("R11 rne irq", {7'd0, irq}, 8'd1);
    rne_ie = 1'b0;

    // R5 data and status read in the same cycle do not clear
    rx_word_done = 1'b1; tick();
    chk("R3 overrun", {7'd0, ovr_flag}, 8'd1);
    err_ie = 1'b1; #1;
    chk("R11 overrun irq", {7'd0, irq}, 8'd1);
    err_ie = 1'b0;
    dat_rd = 1'b1; sts_rd = 1'b1; tick();
    chk("R5 same-cycle reads keep", {7'd0, ovr_flag}, 8'd1);

    // R10 disable clears overrun
    port_en = 1'b0; tick();
    chk("R10 disable clears overrun", {7'd0, ovr_flag}, 8'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule